// File: doc/BRIEF.md
# Quad Gated-Clock Flip-Flop Bank

This block stores four independent data bits, each in a master-slave D-type cell. A bit does not have a clock of its own. Its effective clock is the OR of one shared clock input and that bit's active-low enable line. A bit's master stage follows its data input while the effective clock is low. The value moves to the output on the effective clock's rising edge.

Two clocking styles follow from this. In shared clocking the enables sit low and the common clock steps all four bits together. Raising one bit's enable parks its effective clock high, so that bit ignores the common clock. In individual clocking the common clock sits low and each bit is stepped by pulsing its own enable line.

Every bit has its own asynchronous clear. The asynchronous presets are shared by mirrored pairs of bits: the outer pair (bits 0 and 3) and the inner pair (bits 1 and 2). Each bit drives a true output and a complementary output. The block has no streaming data path, so all pins are plain level signals.

Top module: `quad_gff`

## Requirements
- R1: On the rising edge of its effective clock (`cclk_i` OR `ce_n_i[k]`), bit k loads into `q_o[k]` the value `d_i[k]` held just before that edge.
- R2: `q_o` changes on no other clock event. A change of `d_i` while the effective clock is high, or a falling effective-clock edge, leaves the output unchanged.
- R3: With `cclk_i` held low, a low-high-low pulse on `ce_n_i[k]` updates bit k only. The other three bits keep their values.
- R4: With all `ce_n_i` low, a rising edge of `cclk_i` updates all four bits. A bit whose `ce_n_i` line is already held high keeps its value across `cclk_i` edges.
- R5: `rst_i[k]` high forces `q_o[k]` to 0 at once, with no clock edge needed. The other bits are not affected.
- R6: `set_i[0]` high forces bits 0 and 3 to 1 at once. `set_i[1]` high forces bits 1 and 2 to 1 at once.
- R7: When `rst_i[k]` and the preset covering bit k are both high, bit k reads 0.
- R8: `qb_o` is always the bitwise complement of `q_o`.
- R9: After a clear or preset is released, the bit keeps its forced value until its next effective rising edge. That edge loads `d_i[k]` as in R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cclk_i | input | 1 | Common clock shared by all bits |
| ce_n_i | input | 4 | Per-bit active-low enable, ORed into that bit's clock |
| d_i | input | 4 | Per-bit data |
| rst_i | input | 4 | Per-bit asynchronous clear, active high |
| set_i | input | 2 | Paired asynchronous preset: [0] for bits 0 and 3, [1] for bits 1 and 2 |
| q_o | output | 4 | True outputs |
| qb_o | output | 4 | Complementary outputs |

## Verification
The assertions assume three things about the inputs. Data is steady around each effective rising edge. A clear or preset is raised and dropped only while that bit's effective clock is low. When a clear and a preset overlap, the preset is dropped before the clear. The directed stimulus keeps to these rules by:
- moving each input on its own half-period step of the bench clock;
- applying every asynchronous control with both the common clock and the enables low;
- releasing overlapping controls preset first, clear second.

// File: rtl/qff_pkg.sv
package qff_pkg;

  // Mirrored pairing: bit k shares a preset with bit (n-1-k).
  function automatic int grp_of(input int k, input int n);
    if (k < n - 1 - k) return k;
    return n - 1 - k;
  endfunction

endpackage

// File: rtl/qff_clkgate.sv
module qff_clkgate #(
  parameter int NBITS = 4
) (
  input  logic             cclk_i,
  input  logic [NBITS-1:0] ce_n_i,
  output logic [NBITS-1:0] eclk_o
);

  // One OR per bit: an enable held high parks that bit's clock high.
  for (genvar k = 0; k < NBITS; k++) begin : g_or
    assign eclk_o[k] = cclk_i | ce_n_i[k];
  end

endmodule

// File: rtl/qff_setmap.sv
module qff_setmap #(
  parameter int NBITS = 4,
  localparam int NGRP = NBITS / 2
) (
  input  logic [NGRP-1:0]  set_i,
  output logic [NBITS-1:0] bit_set_o
);

  for (genvar k = 0; k < NBITS; k++) begin : g_route
    localparam int G = qff_pkg::grp_of(k, NBITS);
    assign bit_set_o[k] = set_i[G];
  end

endmodule

// File: rtl/qff_msbit.sv
module qff_msbit (
  input  logic eclk_i,
  input  logic d_i,
  input  logic rst_i,
  input  logic set_i,
  output logic q_o,
  output logic qb_o
);

  logic m_q;
  logic s_q;

  // Master: transparent while the effective clock is low.
  always_latch begin
    if (!eclk_i) m_q <= d_i;
  end

  // Slave: loads on the rising edge; the clear outranks the preset.
  always_ff @(posedge eclk_i or posedge rst_i or posedge set_i) begin
    if (rst_i)      s_q <= 1'b0;
    else if (set_i) s_q <= 1'b1;
    else            s_q <= m_q;
  end

  assign q_o  = s_q;
  assign qb_o = ~s_q;

  // R1: after a high phase the slave holds what the master closed on.
  p_capture_r1: assert property (@(negedge eclk_i) disable iff (rst_i || set_i)
    s_q == m_q)
    else $error("p_capture_r1");

  // R5: a clear present before the edge keeps the bit at 0.
  p_clear_r5: assert property (@(posedge eclk_i) disable iff (set_i)
    rst_i |-> !s_q)
    else $error("p_clear_r5");

  // R6: a preset present before the edge keeps the bit at 1.
  p_preset_r6: assert property (@(posedge eclk_i) disable iff (rst_i)
    set_i |-> s_q)
    else $error("p_preset_r6");

  // R7: with both forces present, the bit reads 0.
  p_clear_wins_r7: assert property (@(posedge eclk_i) disable iff (!set_i)
    rst_i |-> !s_q)
    else $error("p_clear_wins_r7");

endmodule

// File: rtl/quad_gff.sv
module quad_gff #(
  parameter int NBITS = 4
) (
  input  logic               cclk_i,
  input  logic [NBITS-1:0]   ce_n_i,
  input  logic [NBITS-1:0]   d_i,
  input  logic [NBITS-1:0]   rst_i,
  input  logic [NBITS/2-1:0] set_i,
  output logic [NBITS-1:0]   q_o,
  output logic [NBITS-1:0]   qb_o
);

  logic [NBITS-1:0] eclk;
  logic [NBITS-1:0] bit_set;

  qff_clkgate #(.NBITS(NBITS)) u_gate (
    .cclk_i (cclk_i),
    .ce_n_i (ce_n_i),
    .eclk_o (eclk)
  );

  qff_setmap #(.NBITS(NBITS)) u_setmap (
    .set_i     (set_i),
    .bit_set_o (bit_set)
  );

  for (genvar k = 0; k < NBITS; k++) begin : g_bit
    qff_msbit u_cell (
      .eclk_i (eclk[k]),
      .d_i    (d_i[k]),
      .rst_i  (rst_i[k]),
      .set_i  (bit_set[k]),
      .q_o    (q_o[k]),
      .qb_o   (qb_o[k])
    );
  end

endmodule

// File: tb/quad_gff_tb.sv
`timescale 1ns/1ps
module quad_gff_tb;

  logic       clk    = 1'b0;
  logic       cclk   = 1'b1;
  logic [3:0] ce_n   = 4'h0;
  logic [3:0] d      = 4'h0;
  logic [3:0] rst    = 4'h0;
  logic [1:0] set    = 2'b00;
  logic [3:0] q;
  logic [3:0] qb;
  logic [3:0] exp_q;
  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  quad_gff u_dut (
    .cclk_i (cclk),
    .ce_n_i (ce_n),
    .d_i    (d),
    .rst_i  (rst),
    .set_i  (set),
    .q_o    (q),
    .qb_o   (qb)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic pulse_common();
    step(); cclk = 1'b1;
    step(); cclk = 1'b0;
    step();
  endtask

  task automatic t_reset_state();
    #1 rst = 4'hF;
    step(); cclk = 1'b0;
    step();
    chk("R5 reset state", q, 4'h0);
    chk("R8 reset complement", qb, 4'hF);
    rst = 4'h0;
    step();
    chk("R9 hold after clear release", q, 4'h0);
    exp_q = 4'h0;
  endtask

  task automatic t_shared(input logic [3:0] pat);
    d = pat;
    pulse_common();
    exp_q = pat;
    chk("R4 shared load", q, exp_q);
    chk("R1 shared load", q, pat);
    chk("R8 complement", qb, ~exp_q);
  endtask

  task automatic t_blocked(input logic [3:0] mask);
    d = exp_q;
    step(); ce_n = mask;
    step();
    chk("R4 enable rise reloads same", q, exp_q);
    d = ~exp_q;
    step(); cclk = 1'b1;
    step();
    exp_q = (exp_q & mask) | (d & ~mask);
    chk("R4 blocked bits hold", q, exp_q);
    cclk = 1'b0;
    step(); ce_n = 4'h0;
    step();
    chk("R2 enable fall no load", q, exp_q);
  endtask

  task automatic t_individual();
    for (int k = 0; k < 4; k++) begin
      d = ~exp_q;
      step(); ce_n[k] = 1'b1;
      step();
      exp_q[k] = d[k];
      chk("R3 single bit load", q, exp_q);
      ce_n[k] = 1'b0;
      step();
    end
  endtask

  task automatic t_high_phase();
    d = 4'h6;
    step(); cclk = 1'b1;
    step();
    exp_q = 4'h6;
    chk("R1 load before high phase", q, exp_q);
    d = 4'h9;
    step();
    chk("R2 data change in high phase", q, exp_q);
    cclk = 1'b0;
    step();
    chk("R2 falling edge", q, exp_q);
    pulse_common();
    exp_q = 4'h9;
    chk("R1 next edge loads new data", q, exp_q);
  endtask

  task automatic t_clear();
    t_shared(4'hF);
    rst = 4'b0010;
    step();
    chk("R5 clear bit1 only", q, 4'b1101);
    rst = 4'h0;
    step();
    chk("R9 clear release holds", q, 4'b1101);
    d = 4'b1011;
    pulse_common();
    exp_q = 4'b1011;
    chk("R9 edge after clear loads", q, exp_q);
  endtask

  task automatic t_preset();
    t_shared(4'h0);
    set = 2'b01;
    step();
    chk("R6 outer pair preset", q, 4'b1001);
    set = 2'b10;
    step();
    chk("R6 inner pair preset", q, 4'b1111);
    set = 2'b00;
    step();
    chk("R9 preset release holds", q, 4'hF);
    d = 4'b0100;
    pulse_common();
    exp_q = 4'b0100;
    chk("R9 edge after preset loads", q, exp_q);
  endtask

  task automatic t_conflict();
    t_shared(4'h0);
    set = 2'b01; rst = 4'b0001;
    step();
    chk("R7 clear wins bit0", q, 4'b1000);
    set = 2'b10;
    step();
    rst = 4'b0101;
    step();
    chk("R7 clear over inner preset", q, 4'b1010);
    chk("R8 complement under force", qb, 4'b0101);
    set = 2'b00;
    step(); rst = 4'h0;
    step();
    chk("R9 release after conflict", q, 4'b1010);
  endtask

  initial begin
    #500_000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_shared(4'hA);
    t_shared(4'h5);
    t_shared(4'h3);
    t_blocked(4'b0101);
    t_blocked(4'b1000);
    t_individual();
    t_high_phase();
    t_clear();
    t_preset();
    t_conflict();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule